// File: doc/BRIEF.md
# Serial Memory Slave Front-End

This block is the serial slave port of a small memory device. It oversamples the serial clock, the active-low select, the active-low pause input and the data input in the chip clock domain. It assembles bytes most significant bit first, and the first complete byte of every selection is the command. A command found in a configurable table is passed to the downstream command handler with a strobe. Every later byte of the same selection is passed on as a data byte. A command not found in the table puts the port into a locked state. In that state it ignores input and keeps its output released until the select is deasserted.

Read data comes back from the handler one byte at a time. The handler indicates that it wants to drive the line. The front end takes the presented byte at the first falling serial clock edge of each byte slot, pulses an acknowledge, and shifts the byte out on falling edges. The output has its own enable so that the pad can float.

The pause input freezes the transfer at its current bit without losing its place. Its entry and release are only recognised while the serial clock is low. Both serial clock modes 0 and 3 work, because only the edges are used and never the idle level.

Top module: `spi_mem_slave_fe`

## Requirements
- R1: In clock mode 0 (clock idle low) and in mode 3 (clock idle high), the data input is sampled on rising serial clock edges and the data output changes only after falling edges.
- R2: Bytes are received and sent most significant bit first.
- R3: The first complete byte after select goes low is the command. If it is in the table of valid commands (default 0x01 to 0x06), `op_stb` pulses once with the byte on `op_code`. At most one of `op_stb`, `op_bad` and `byte_stb` is high in any cycle.
- R4: Each later complete byte in the same selection pulses `byte_stb` once, with the byte on `byte_data`.
- R5: A command not in the table pulses `op_bad`. After that, no strobe is produced and `so_oe` stays low until select goes high. The next selection decodes a fresh command.
- R6: While select is high, data input and clock edges are ignored, `so_oe` is low, and a partial byte is discarded. The next selection starts again at the command bit 7.
- R7: `so_oe` is high only after a valid command, with `tx_en` high, from the first falling edge of the following byte slot. At that edge `tx_byte` is loaded and `tx_take` pulses once. `so_oe` stays low during the command byte.
- R8: A pause starts only while the serial clock is low and ends only while it is low. A pause input that drops while the clock is high leaves the output driven until the clock falls.
- R9: While paused, clock edges and the data input have no effect and `so_oe` is low. After release, reception and transmission continue at the same bit.
- R10: When the pause input drops while the clock is high, the following falling edge still advances the output before the pause begins. A release made while the clock is high takes effect at the next falling edge, and that edge does not advance the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the master |
| cs_n | input | 1 | Active-low select |
| hold_n | input | 1 | Active-low pause request |
| si | input | 1 | Serial data in |
| tx_en | input | 1 | Handler wants the output driven for this command |
| tx_byte | input | 8 | Next read byte offered by the handler |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the data-out pad |
| tx_take | output | 1 | Pulse: `tx_byte` was loaded into the output shifter |
| op_stb | output | 1 | Pulse: valid command received |
| op_code | output | 8 | Received command byte |
| op_bad | output | 1 | Pulse: command not in the table |
| byte_stb | output | 1 | Pulse: data byte received after the command |
| byte_data | output | 8 | Received data byte |

## Verification
The pause logic and the output shifter can act in the same chip clock cycle. This happens when the pause input was dropped while the clock was high and the clock then falls: in that one cycle the shifter advances and the pause is taken. The bench provokes it in the middle of a read byte. It first checks that the output stays enabled while the clock is still high. It then checks that the output floats after the fall. It then releases the pause while the clock is high and lets the clock fall. The next sampled bits must continue the expected read byte, with no bit repeated and none skipped.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        PH_OPCODE = 2'd0,
        PH_DATA   = 2'd1,
        PH_LOCKED = 2'd2
    } phase_e;

    typedef struct packed {
        logic sck;
        logic cs_n;
        logic hold_n;
        logic si;
    } pins_t;

    typedef struct packed {
        logic  stb;
        byte_t val;
    } byte_evt_t;

    localparam pins_t PINS_IDLE = '{sck: 1'b0, cs_n: 1'b1, hold_n: 1'b1, si: 1'b0};

    function automatic byte_t push_bit(byte_t cur, logic b);
        return {cur[BYTE_W-2:0], b};
    endfunction

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync
    import spi_fe_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  pins_t raw,
    output pins_t lvl,
    output logic  sck_rise,
    output logic  sck_fall
);

    pins_t stg [STAGES];
    logic  sck_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) begin
                stg[i] <= PINS_IDLE;
            end
            sck_prev <= 1'b0;
        end else begin
            stg[0] <= raw;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
            sck_prev <= stg[STAGES-1].sck;
        end
    end

    assign lvl      = stg[STAGES-1];
    assign sck_rise =  lvl.sck & ~sck_prev;
    assign sck_fall = ~lvl.sck &  sck_prev;

endmodule

// File: rtl/spi_fe_hold.sv
module spi_fe_hold (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic sck_lvl,
    input  logic hold_n_lvl,
    output logic held
);

    // The pause level is only followed while the serial clock is low.
    always_ff @(posedge clk) begin
        if (rst || !sel) begin
            held <= 1'b0;
        end else if (!sck_lvl) begin
            held <= ~hold_n_lvl;
        end
    end

endmodule

// File: rtl/spi_fe_shift.sv
module spi_fe_shift
    import spi_fe_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sel,
    input  logic      run,
    input  logic      tx_phase,
    input  logic      sck_rise,
    input  logic      sck_fall,
    input  logic      si_lvl,
    input  byte_t     tx_byte,
    output byte_evt_t rx_evt,
    output logic      so_bit,
    output logic      armed,
    output logic      take
);

    logic [CNT_W-1:0] bit_cnt;
    byte_t            rx_sh;
    byte_t            tx_sh;

    always_ff @(posedge clk) begin
        if (rst || !sel) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            rx_evt  <= '0;
            so_bit  <= 1'b0;
            armed   <= 1'b0;
            take    <= 1'b0;
        end else begin
            rx_evt.stb <= 1'b0;
            take       <= 1'b0;
            if (sck_rise && run) begin
                rx_sh <= push_bit(rx_sh, si_lvl);
                if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                    rx_evt.stb <= 1'b1;
                    rx_evt.val <= push_bit(rx_sh, si_lvl);
                    bit_cnt    <= '0;
                end else begin
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end
            end
            if (sck_fall && run && tx_phase) begin
                if (bit_cnt == '0) begin
                    so_bit <= tx_byte[BYTE_W-1];
                    tx_sh  <= {tx_byte[BYTE_W-2:0], 1'b0};
                    armed  <= 1'b1;
                    take   <= 1'b1;
                end else begin
                    so_bit <= tx_sh[BYTE_W-1];
                    tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                end
            end
        end
    end

endmodule

// File: rtl/spi_fe_decode.sv
module spi_fe_decode
    import spi_fe_pkg::*;
#(
    parameter int                     N_OPS    = 6,
    parameter logic [N_OPS*BYTE_W-1:0] OP_TABLE = {8'h06, 8'h05, 8'h04, 8'h03, 8'h02, 8'h01}
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sel,
    input  byte_evt_t rx_evt,
    output phase_e    phase,
    output logic      op_stb,
    output logic      op_bad,
    output byte_t     op_code,
    output logic      byte_stb,
    output byte_t     byte_data
);

    logic [N_OPS-1:0] match;

    for (genvar g = 0; g < N_OPS; g++) begin : g_cmp
        assign match[g] = (OP_TABLE[g*BYTE_W +: BYTE_W] == rx_evt.val);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_code   <= '0;
            byte_data <= '0;
        end else if (sel && rx_evt.stb) begin
            if (phase == PH_DATA) begin
                byte_data <= rx_evt.val;
            end else if (phase == PH_OPCODE) begin
                op_code <= rx_evt.val;
            end
        end
    end

    always_ff @(posedge clk) begin
        op_stb   <= 1'b0;
        op_bad   <= 1'b0;
        byte_stb <= 1'b0;
        if (rst || !sel) begin
            phase <= PH_OPCODE;
        end else if (rx_evt.stb) begin
            unique case (phase)
                PH_OPCODE: begin
                    if (|match) begin
                        op_stb <= 1'b1;
                        phase  <= PH_DATA;
                    end else begin
                        op_bad <= 1'b1;
                        phase  <= PH_LOCKED;
                    end
                end
                PH_DATA:   byte_stb <= 1'b1;
                default:   phase <= PH_LOCKED;
            endcase
        end
    end

endmodule

// File: rtl/spi_mem_slave_fe.sv
module spi_mem_slave_fe
    import spi_fe_pkg::*;
#(
    parameter int                     SYNC_STAGES = 2,
    parameter int                     N_OPS       = 6,
    parameter logic [N_OPS*BYTE_W-1:0] OP_TABLE    = {8'h06, 8'h05, 8'h04, 8'h03, 8'h02, 8'h01}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              hold_n,
    input  logic              si,
    input  logic              tx_en,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              so,
    output logic              so_oe,
    output logic              tx_take,
    output logic              op_stb,
    output logic [BYTE_W-1:0] op_code,
    output logic              op_bad,
    output logic              byte_stb,
    output logic [BYTE_W-1:0] byte_data
);

    pins_t     raw_pins;
    pins_t     pin_lvl;
    logic      sck_rise;
    logic      sck_fall;
    logic      sck_lvl;
    logic      sel;
    logic      held;
    logic      run;
    logic      armed;
    phase_e    phase;
    byte_evt_t rx_evt;

    assign raw_pins = '{sck: sck, cs_n: cs_n, hold_n: hold_n, si: si};

    spi_fe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .raw      (raw_pins),
        .lvl      (pin_lvl),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall)
    );

    assign sel     = ~pin_lvl.cs_n;
    assign sck_lvl = pin_lvl.sck;

    spi_fe_hold u_hold (
        .clk        (clk),
        .rst        (rst),
        .sel        (sel),
        .sck_lvl    (sck_lvl),
        .hold_n_lvl (pin_lvl.hold_n),
        .held       (held)
    );

    assign run = sel && !held && (phase != PH_LOCKED);

    spi_fe_shift u_shift (
        .clk      (clk),
        .rst      (rst),
        .sel      (sel),
        .run      (run),
        .tx_phase (phase == PH_DATA),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .si_lvl   (pin_lvl.si),
        .tx_byte  (tx_byte),
        .rx_evt   (rx_evt),
        .so_bit   (so),
        .armed    (armed),
        .take     (tx_take)
    );

    spi_fe_decode #(.N_OPS(N_OPS), .OP_TABLE(OP_TABLE)) u_decode (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .rx_evt    (rx_evt),
        .phase     (phase),
        .op_stb    (op_stb),
        .op_bad    (op_bad),
        .op_code   (op_code),
        .byte_stb  (byte_stb),
        .byte_data (byte_data)
    );

    assign so_oe = sel && !held && armed && tx_en && (phase == PH_DATA);

endmodule

// File: rtl/spi_fe_checks.sv
module spi_fe_checks
    import spi_fe_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input logic   sel,
    input logic   sck_lvl,
    input logic   sck_fall,
    input logic   held,
    input phase_e phase,
    input logic   so,
    input logic   so_oe,
    input logic   op_stb,
    input logic   op_bad,
    input logic   byte_stb
);

    // R9: a paused port never drives the line
    a_r9_hold_releases_so: assert property (@(posedge clk) disable iff (rst)
        held |-> !so_oe);

    // R8: pause state moves only while the clock is low (or on deselect)
    a_r8_hold_on_sck_low: assert property (@(posedge clk) disable iff (rst)
        (held != $past(held)) |-> (!$past(sck_lvl) || !$past(sel)));

    // R5: locked port is silent
    a_r5_locked_silent: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_LOCKED) |-> (!so_oe && !op_stb && !byte_stb));

    // R5: a rejected command leaves the port locked
    a_r5_bad_locks: assert property (@(posedge clk) disable iff (rst)
        op_bad |-> (phase == PH_LOCKED));

    // R6: deselect reinitialises the sequence
    a_r6_deselect_reinit: assert property (@(posedge clk) disable iff (rst)
        !sel |=> ((phase == PH_OPCODE) && !held));

    // R3: one event per cycle at most
    a_r3_one_event: assert property (@(posedge clk) disable iff (rst)
        $onehot0({op_stb, op_bad, byte_stb}));

    // R4: data bytes only after an accepted command
    a_r4_byte_in_data: assert property (@(posedge clk) disable iff (rst)
        byte_stb |-> (phase == PH_DATA));

    // R1: the output bit moves only after a falling clock edge or a deselect
    a_r1_so_on_fall: assert property (@(posedge clk) disable iff (rst)
        (so != $past(so)) |-> ($past(sck_fall) || !$past(sel)));

endmodule

bind spi_mem_slave_fe spi_fe_checks u_checks (
    .clk      (clk),
    .rst      (rst),
    .sel      (sel),
    .sck_lvl  (sck_lvl),
    .sck_fall (sck_fall),
    .held     (held),
    .phase    (phase),
    .so       (so),
    .so_oe    (so_oe),
    .op_stb   (op_stb),
    .op_bad   (op_bad),
    .byte_stb (byte_stb)
);

// File: tb/spi_mem_slave_fe_test.sv
module spi_mem_slave_fe_test;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sck = 1'b0;
    logic       cs_n = 1'b1;
    logic       hold_n = 1'b1;
    logic       si = 1'b0;
    logic       tx_en = 1'b0;
    logic [7:0] tx_byte;
    logic       so, so_oe, tx_take, op_stb, op_bad, byte_stb;
    logic [7:0] op_code, byte_data;

    int  n_checks = 0;
    int  n_fail = 0;
    int  tx_idx = 0;
    bit  mode3 = 1'b0;
    bit  done = 1'b0;

    typedef struct {
        int         kind;   // 0 command, 1 data byte, 2 rejected command
        logic [7:0] val;
        string      req;
    } exp_t;

    exp_t sb[$];

    always #2 clk = ~clk;

    spi_mem_slave_fe uut (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .hold_n(hold_n), .si(si),
        .tx_en(tx_en), .tx_byte(tx_byte), .so(so), .so_oe(so_oe), .tx_take(tx_take),
        .op_stb(op_stb), .op_code(op_code), .op_bad(op_bad),
        .byte_stb(byte_stb), .byte_data(byte_data)
    );

    function automatic logic [7:0] txf(int k);
        return 8'hA5 ^ 8'(k * 37);
    endfunction

    assign tx_byte = txf(tx_idx);

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(int kind, logic [7:0] val, string req);
        exp_t e;
        e.kind = kind; e.val = val; e.req = req;
        sb.push_back(e);
    endtask

    // Monitor: pops the scoreboard as events appear
    always @(negedge clk) begin
        if (!rst) begin
            if (tx_take) tx_idx++;
            if (op_stb || op_bad || byte_stb) begin
                int         k;
                logic [7:0] v;
                k = op_stb ? 0 : (byte_stb ? 1 : 2);
                v = op_stb ? op_code : byte_data;
                if (sb.size() == 0) begin
                    chk(1'b0, "R5/R6", "unexpected event kind", k, 99);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(e.kind == k, e.req, "event kind", k, e.kind);
                    if (k != 2) chk(v == e.val, e.req, "event byte", v, e.val);
                end
            end
        end
    end

    task automatic wt(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel_on();
        sck = mode3;
        tx_idx = 0;
        wt(HALF);
        cs_n = 1'b0;
        wt(HALF);
    endtask

    task automatic sel_off();
        wt(HALF);
        cs_n = 1'b1;
        wt(2 * HALF);
    endtask

    // hk: 0 none, 1 pause entered and left with clock low, 2 entered and left with clock high
    task automatic xfer(input logic [7:0] b, input bit oe_exp, input bit rd_cmp,
                        input logic [7:0] rd_exp, input int hk, input int hb, input string req);
        logic [7:0] got;
        bit         oe_ok;
        oe_ok = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            if (mode3) sck = 1'b0;
            si = b[i];
            wt(HALF);
            got[i] = so;
            if (so_oe != oe_exp) oe_ok = 1'b0;
            sck = 1'b1;
            wt(HALF);
            if (!mode3) begin
                if (hk == 2 && i == hb) begin
                    hold_n = 1'b0;
                    wt(HALF);
                    chk(so_oe == oe_exp, "R8", "oe kept while clock high", so_oe, oe_exp);
                    sck = 1'b0;
                    wt(HALF);
                    chk(so_oe == 1'b0, "R10", "oe after entry fall", so_oe, 0);
                    si = ~si; sck = 1'b1; wt(HALF);
                    sck = 1'b0; wt(HALF);
                    sck = 1'b1; wt(HALF);
                    hold_n = 1'b1;
                    wt(HALF);
                    chk(so_oe == 1'b0, "R8", "release ignored while clock high", so_oe, 0);
                end
                sck = 1'b0;
                if (hk == 1 && i == hb) begin
                    wt(HALF);
                    hold_n = 1'b0;
                    wt(HALF);
                    chk(so_oe == 1'b0, "R9", "oe during pause", so_oe, 0);
                    si = ~si; sck = 1'b1; wt(HALF);
                    sck = 1'b0; wt(HALF);
                    hold_n = 1'b1;
                    wt(HALF);
                end
            end
        end
        chk(oe_ok, req, "so_oe level over byte", 0, 0);
        if (rd_cmp) chk(got == rd_exp, "R2", "read byte msb first", got, rd_exp);
    endtask

    initial begin
        wt(5);
        chk(so_oe == 1'b0 && !op_stb && !byte_stb, "R6", "reset quiet", so_oe, 0);
        rst = 1'b0;
        wt(10);
        chk(so_oe == 1'b0, "R6", "idle oe", so_oe, 0);

        // Mode 0 read with handler driving
        tx_en = 1'b1; mode3 = 1'b0;
        sel_on();
        push(0, 8'h03, "R3");
        xfer(8'h03, 1'b0, 1'b0, 8'h00, 0, 0, "R7");
        push(1, 8'h12, "R4"); xfer(8'h12, 1'b1, 1'b1, txf(0), 0, 0, "R1");
        push(1, 8'h80, "R4"); xfer(8'h80, 1'b1, 1'b1, txf(1), 0, 0, "R1");
        push(1, 8'h01, "R4"); xfer(8'h01, 1'b1, 1'b1, txf(2), 0, 0, "R1");
        push(1, 8'h00, "R4"); xfer(8'h00, 1'b1, 1'b1, txf(3), 0, 0, "R7");
        sel_off();

        // Mode 3 with another command
        mode3 = 1'b1;
        sel_on();
        push(0, 8'h02, "R3");
        xfer(8'h02, 1'b0, 1'b0, 8'h00, 0, 0, "R7");
        push(1, 8'hC7, "R4"); xfer(8'hC7, 1'b1, 1'b1, txf(0), 0, 0, "R1");
        push(1, 8'h3C, "R4"); xfer(8'h3C, 1'b1, 1'b1, txf(1), 0, 0, "R1");
        sel_off();
        chk(so_oe == 1'b0, "R6", "oe after deselect", so_oe, 0);

        // Handler not driving
        mode3 = 1'b0; tx_en = 1'b0;
        sel_on();
        push(0, 8'h05, "R3");
        xfer(8'h05, 1'b0, 1'b0, 8'h00, 0, 0, "R7");
        push(1, 8'hFF, "R4"); xfer(8'hFF, 1'b0, 1'b0, 8'h00, 0, 0, "R7");
        sel_off();

        // Rejected command, then recovery
        tx_en = 1'b1;
        sel_on();
        push(2, 8'h7E, "R5");
        xfer(8'h7E, 1'b0, 1'b0, 8'h00, 0, 0, "R5");
        xfer(8'h03, 1'b0, 1'b0, 8'h00, 0, 0, "R5");
        xfer(8'h55, 1'b0, 1'b0, 8'h00, 0, 0, "R5");
        sel_off();
        sel_on();
        push(0, 8'h06, "R5");
        xfer(8'h06, 1'b0, 1'b0, 8'h00, 0, 0, "R5");
        sel_off();

        // Clock and data while deselected
        for (int j = 0; j < 16; j++) begin
            si = j[0] ^ j[2];
            sck = ~sck;
            wt(HALF);
            if (so_oe) chk(1'b0, "R6", "oe while deselected", so_oe, 0);
        end
        chk(so_oe == 1'b0, "R6", "deselected quiet", so_oe, 0);
        sck = 1'b0;

        // Partial byte discarded on deselect
        mode3 = 1'b0;
        sel_on();
        for (int i = 0; i < 4; i++) begin
            si = 1'b1; wt(HALF); sck = 1'b1; wt(HALF); sck = 1'b0;
        end
        sel_off();
        sel_on();
        push(0, 8'h01, "R6");
        xfer(8'h01, 1'b0, 1'b0, 8'h00, 0, 0, "R6");
        push(1, 8'hC3, "R6");
        xfer(8'hC3, 1'b1, 1'b1, txf(0), 0, 0, "R6");
        sel_off();

        // Pause tests
        sel_on();
        push(0, 8'h03, "R9");
        xfer(8'h03, 1'b0, 1'b0, 8'h00, 0, 0, "R9");
        push(1, 8'h5A, "R9");
        xfer(8'h5A, 1'b1, 1'b1, txf(0), 1, 4, "R9");
        push(1, 8'h96, "R10");
        xfer(8'h96, 1'b1, 1'b1, txf(1), 2, 5, "R10");
        push(1, 8'h2B, "R10");
        xfer(8'h2B, 1'b1, 1'b1, txf(2), 0, 0, "R10");
        sel_off();

        wt(10);
        chk(sb.size() == 0, "R4", "events outstanding", sb.size(), 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule